// File: doc/BRIEF.md
# Indexed PLL Configuration Register Bank

This block is a register file that lets software set up several PLL channels through one narrow window of addresses. A channel index, loaded through the update register, chooses which channel the control and analog registers refer to. Writes to those registers only change a shared staging copy. The settings reach the chosen channel's live configuration when software writes the update register with its commit bit set. Because of this, a divider, multiplier and enable change can be applied to a PLL in a single step.

Each channel has a live configuration that is driven out as three 32-bit words. Each channel also models a lock flag. The flag rises a fixed number of clock cycles after a commit that turns the PLL on with lock detection enabled, or that changes its divider, multiplier or fractional value. Software stops a PLL in two steps. It first commits with the output clock enable cleared and the loop still running. It then commits with the PLL enable cleared. The output rate is the input rate × (mul+1)/(div+1), because both fields hold their value minus one.

Top module: `pll_cfg_bank`

## Requirements
- R1: After reset, every channel's control words are zero, its analog word is 0x1B040010, every lock flag is low, and the selected channel is 0.
- R2: Writes to offsets 0x0C, 0x10 and 0x18 change neither the channel outputs nor the readback of those offsets until a commit.
- R3: Writing offset 0x1C with bit 8 set copies the staged words into the selected channel in the same clock edge. All other channels stay unchanged, and the selection is kept.
- R4: Writing offset 0x1C with bit 8 clear loads the channel index from the low bits of the data. It also reloads the staging copy from that channel's live words, so a commit after a partial edit keeps the untouched words.
- R5: Control word 0 keeps only the divider (bits 7:0), PLL enable (bit 28), output clock enable (bit 29) and lock-detect enable (bit 31). Control word 1 keeps only the fraction (bits 21:0) and the multiplier (bits 30:24). All other bits read as zero. The analog word keeps all 32 bits.
- R6: Reads of 0x0C, 0x10 and 0x18 return the selected channel's live words. A read of 0x1C returns the index in its low bits, with bit 8 always zero. Bit n of a read of 0xEC is channel n's lock flag.
- R7: Reads of any other offset return zero. Writes to any other offset, and writes to 0xEC, change nothing.
- R8: A commit whose control word 0 has bits 28 and 31 set drops the lock flag on the next edge if the channel was not already set that way, or if the divider, multiplier or fraction differ. The flag then rises exactly LOCK_DLY edges after the commit edge.
- R9: A commit with bit 28 or bit 31 clear drops the channel's lock flag on the commit edge and keeps it low.
- R10: A commit that keeps bits 28 and 31 set and leaves the divider, multiplier and fraction unchanged leaves the lock flag and the running count as they are. This holds, for example, when only the output clock enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| ctrl0_o | output | NUM_CH*32 | Live control word 0 of each channel |
| ctrl1_o | output | NUM_CH*32 | Live control word 1 of each channel |
| analog_o | output | NUM_CH*32 | Live analog word of each channel |
| lock_ready_o | output | NUM_CH | Lock flag of each channel |

## Verification
A staging copy that leaks early shows up on the channel outputs on the edge after a plain register write, well before any commit. A wrong selection shows up as a commit that lands on the wrong channel, or as a partial edit that wipes a word of the other channel, and this is visible on the next readback. A lock timer that is off by one, or that restarts when it should not, is seen by sampling the status bit every cycle after each commit. That includes the first step of the shutdown sequence, where the flag must not move.

// File: rtl/pll_cfg_pkg.sv
`timescale 1ns/1ps
package pll_cfg_pkg;
  localparam int REG_W   = 32;
  localparam int DIV_W   = 8;
  localparam int KEY_W   = DIV_W + REG_W;
  localparam int UPD_BIT = 8;
  localparam int EN_BIT  = 28;
  localparam int LKEN_BIT = 31;

  localparam logic [7:0] OFS_CTRL0  = 8'h0C;
  localparam logic [7:0] OFS_CTRL1  = 8'h10;
  localparam logic [7:0] OFS_ANALOG = 8'h18;
  localparam logic [7:0] OFS_UPDATE = 8'h1C;
  localparam logic [7:0] OFS_STATUS = 8'hEC;

  localparam logic [REG_W-1:0] CTRL0_KEEP  = 32'hB000_00FF;
  localparam logic [REG_W-1:0] CTRL1_KEEP  = 32'h7F3F_FFFF;
  localparam logic [REG_W-1:0] ANALOG_INIT = 32'h1B04_0010;

  typedef struct packed {
    logic [REG_W-1:0] w0;
    logic [REG_W-1:0] w1;
    logic [REG_W-1:0] an;
  } pll_cfg_t;

  localparam pll_cfg_t CFG_INIT = '{w0: '0, w1: '0, an: ANALOG_INIT};

  typedef enum logic [2:0] {
    RD_NONE, RD_W0, RD_W1, RD_AN, RD_UPD, RD_STAT
  } rd_src_e;

  function automatic logic lock_wanted(input logic [REG_W-1:0] w0);
    return w0[EN_BIT] & w0[LKEN_BIT];
  endfunction

  function automatic logic [KEY_W-1:0] loop_key(input pll_cfg_t c);
    return {c.w0[DIV_W-1:0], c.w1 & CTRL1_KEEP};
  endfunction
endpackage

// File: rtl/pll_cfg_decode.sv
`timescale 1ns/1ps
module pll_cfg_decode
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic              wr_w0_o,
  output logic              wr_w1_o,
  output logic              wr_an_o,
  output logic              sel_evt_o,
  output logic              commit_evt_o,
  output rd_src_e           rd_src_o
);
  logic hit_w0, hit_w1, hit_an, hit_up, hit_st;

  assign hit_w0 = (addr_i == ADDR_W'(OFS_CTRL0));
  assign hit_w1 = (addr_i == ADDR_W'(OFS_CTRL1));
  assign hit_an = (addr_i == ADDR_W'(OFS_ANALOG));
  assign hit_up = (addr_i == ADDR_W'(OFS_UPDATE));
  assign hit_st = (addr_i == ADDR_W'(OFS_STATUS));

  assign wr_w0_o      = we_i & hit_w0;
  assign wr_w1_o      = we_i & hit_w1;
  assign wr_an_o      = we_i & hit_an;
  assign sel_evt_o    = we_i & hit_up & ~wdata_i[UPD_BIT];
  assign commit_evt_o = we_i & hit_up &  wdata_i[UPD_BIT];

  always_comb begin
    rd_src_o = RD_NONE;
    if (hit_w0)      rd_src_o = RD_W0;
    else if (hit_w1) rd_src_o = RD_W1;
    else if (hit_an) rd_src_o = RD_AN;
    else if (hit_up) rd_src_o = RD_UPD;
    else if (hit_st) rd_src_o = RD_STAT;
  end
endmodule

// File: rtl/pll_cfg_chan.sv
`timescale 1ns/1ps
module pll_cfg_chan
  import pll_cfg_pkg::*;
#(
  parameter int LOCK_DLY = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     commit_i,
  input  pll_cfg_t cfg_i,
  output pll_cfg_t cfg_o,
  output logic     ready_o,
  output logic     busy_o,
  output logic     start_o,
  output logic     stop_o
);
  localparam int CNT_W = $clog2(LOCK_DLY + 1);

  pll_cfg_t         cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, ready_q;
  logic             new_req, old_req, same_loop;

  assign new_req   = lock_wanted(cfg_i.w0);
  assign old_req   = lock_wanted(cfg_q.w0);
  assign same_loop = (loop_key(cfg_i) == loop_key(cfg_q));
  assign start_o   = commit_i & new_req & (~old_req | ~same_loop);
  assign stop_o    = commit_i & ~new_req;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q   <= CFG_INIT;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      if (commit_i) cfg_q <= cfg_i;
      if (stop_o) begin
        ready_q <= 1'b0;
        busy_q  <= 1'b0;
      end else if (start_o) begin
        ready_q <= 1'b0;
        busy_q  <= 1'b1;
        cnt_q   <= CNT_W'(LOCK_DLY);
      end else if (busy_q) begin
        if (cnt_q == CNT_W'(1)) begin
          ready_q <= 1'b1;
          busy_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign ready_o = ready_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/pll_cfg_bank.sv
`timescale 1ns/1ps
module pll_cfg_bank
  import pll_cfg_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int ADDR_W   = 8,
  parameter int LOCK_DLY = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic                    bus_we_i,
  input  logic [REG_W-1:0]        bus_wdata_i,
  output logic [REG_W-1:0]        bus_rdata_o,
  output logic [NUM_CH*REG_W-1:0] ctrl0_o,
  output logic [NUM_CH*REG_W-1:0] ctrl1_o,
  output logic [NUM_CH*REG_W-1:0] analog_o,
  output logic [NUM_CH-1:0]       lock_ready_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              wr_w0, wr_w1, wr_an, sel_evt, commit_evt, stage_wr;
  rd_src_e           rd_src;
  logic [CH_W-1:0]   sel_q, new_idx;
  logic              idx_ok;
  pll_cfg_t          stg_q, sel_cfg, new_cfg;
  pll_cfg_t          act [NUM_CH];
  logic [NUM_CH-1:0] start_vec, stop_vec, busy_vec, ready_vec;

  pll_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i      (bus_addr_i),
    .we_i        (bus_we_i),
    .wdata_i     (bus_wdata_i),
    .wr_w0_o     (wr_w0),
    .wr_w1_o     (wr_w1),
    .wr_an_o     (wr_an),
    .sel_evt_o   (sel_evt),
    .commit_evt_o(commit_evt),
    .rd_src_o    (rd_src)
  );

  assign stage_wr = bus_we_i & ~(sel_evt | commit_evt);
  assign new_idx  = bus_wdata_i[CH_W-1:0];
  assign idx_ok   = (int'(new_idx) < NUM_CH);

  always_comb begin
    sel_cfg = CFG_INIT;
    new_cfg = CFG_INIT;
    for (int n = 0; n < NUM_CH; n++) begin
      if (sel_q == CH_W'(n))   sel_cfg = act[n];
      if (new_idx == CH_W'(n)) new_cfg = act[n];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sel_q <= '0;
      stg_q <= CFG_INIT;
    end else if (sel_evt) begin
      if (idx_ok) begin
        sel_q <= new_idx;
        stg_q <= new_cfg;
      end
    end else begin
      if (wr_w0) stg_q.w0 <= bus_wdata_i & CTRL0_KEEP;
      if (wr_w1) stg_q.w1 <= bus_wdata_i & CTRL1_KEEP;
      if (wr_an) stg_q.an <= bus_wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pll_cfg_chan #(.LOCK_DLY(LOCK_DLY)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .commit_i(commit_evt && (sel_q == CH_W'(g))),
      .cfg_i   (stg_q),
      .cfg_o   (act[g]),
      .ready_o (ready_vec[g]),
      .busy_o  (busy_vec[g]),
      .start_o (start_vec[g]),
      .stop_o  (stop_vec[g])
    );
    assign ctrl0_o[g*REG_W +: REG_W]  = act[g].w0;
    assign ctrl1_o[g*REG_W +: REG_W]  = act[g].w1;
    assign analog_o[g*REG_W +: REG_W] = act[g].an;
  end

  assign lock_ready_o = ready_vec;

  always_comb begin
    case (rd_src)
      RD_W0:   bus_rdata_o = sel_cfg.w0;
      RD_W1:   bus_rdata_o = sel_cfg.w1;
      RD_AN:   bus_rdata_o = sel_cfg.an;
      RD_UPD:  bus_rdata_o = REG_W'(sel_q);
      RD_STAT: bus_rdata_o = REG_W'(ready_vec);
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pll_cfg_bank_chk.sv
`timescale 1ns/1ps
module pll_cfg_bank_chk
  import pll_cfg_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    stage_wr,
  input logic                    commit_evt,
  input logic [CH_W-1:0]         sel_q,
  input pll_cfg_t                stg_q,
  input logic [NUM_CH*REG_W-1:0] ctrl0_o,
  input logic [NUM_CH*REG_W-1:0] ctrl1_o,
  input logic [NUM_CH*REG_W-1:0] analog_o,
  input logic [NUM_CH-1:0]       lock_ready_o,
  input logic [NUM_CH-1:0]       start_vec,
  input logic [NUM_CH-1:0]       stop_vec,
  input logic [NUM_CH-1:0]       busy_vec
);
  p_stage_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_wr |=> ($stable(ctrl0_o) && $stable(ctrl1_o) && $stable(analog_o)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_p
    p_commit_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_evt && sel_q == CH_W'(g)) |=>
        (ctrl0_o[g*REG_W +: REG_W] == $past(stg_q.w0)) &&
        (ctrl1_o[g*REG_W +: REG_W] == $past(stg_q.w1)) &&
        (analog_o[g*REG_W +: REG_W] == $past(stg_q.an)));

    p_other_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_evt && sel_q != CH_W'(g)) |=>
        ($stable(ctrl0_o[g*REG_W +: REG_W]) && $stable(ctrl1_o[g*REG_W +: REG_W])));

    p_field_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ctrl0_o[g*REG_W +: REG_W] & ~CTRL0_KEEP) == '0) &&
      ((ctrl1_o[g*REG_W +: REG_W] & ~CTRL1_KEEP) == '0));

    p_relock_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_vec[g] |=> (!lock_ready_o[g] && busy_vec[g]));

    p_rise_after_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_ready_o[g]) |-> $past(busy_vec[g]));

    p_stop_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_vec[g] |=> (!lock_ready_o[g] && !busy_vec[g]));

    p_start_stop_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(start_vec[g] && stop_vec[g]));
  end
endmodule

bind pll_cfg_bank pll_cfg_bank_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stage_wr    (stage_wr),
  .commit_evt  (commit_evt),
  .sel_q       (sel_q),
  .stg_q       (stg_q),
  .ctrl0_o     (ctrl0_o),
  .ctrl1_o     (ctrl1_o),
  .analog_o    (analog_o),
  .lock_ready_o(lock_ready_o),
  .start_vec   (start_vec),
  .stop_vec    (stop_vec),
  .busy_vec    (busy_vec)
);

// File: tb/test_pll_cfg_bank.sv
`timescale 1ns/1ps
module test_pll_cfg_bank;
  localparam int NCH = 2;
  localparam int DLY = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCH*32-1:0] c0_o, c1_o, an_o;
  logic [NCH-1:0]    rdy;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] e0 [NCH];
  logic [31:0] e1 [NCH];
  logic [31:0] ea [NCH];

  always #5 clk = ~clk;

  pll_cfg_bank #(.NUM_CH(NCH), .ADDR_W(8), .LOCK_DLY(DLY)) i_pll_cfg_bank (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ctrl0_o(c0_o),
    .ctrl1_o(c1_o), .analog_o(an_o), .lock_ready_o(rdy));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic sel(input int ch);
    wr(8'h1C, 32'(ch));
  endtask

  task automatic commit(input int ch, input logic [31:0] w0, input logic [31:0] w1,
                        input logic [31:0] an);
    sel(ch);
    wr(8'h0C, w0);
    wr(8'h10, w1);
    wr(8'h18, an);
    wr(8'h1C, 32'h100);
    e0[ch] = w0 & 32'hB00000FF;
    e1[ch] = w1 & 32'h7F3FFFFF;
    ea[ch] = an;
  endtask

  task automatic cmp_outputs(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " ctrl0"}, c0_o[c*32 +: 32], e0[c]);
      chk({tag, " ctrl1"}, c1_o[c*32 +: 32], e1[c]);
      chk({tag, " analog"}, an_o[c*32 +: 32], ea[c]);
    end
  endtask

  // called right after the commit write returns; j counts edges since commit
  task automatic lock_watch(input int ch, input string tag);
    logic [31:0] s;
    for (int j = 0; j <= DLY + 1; j++) begin
      rd(8'hEC, s);
      chk(tag, 32'(s[ch]), 32'(j >= DLY));
      @(negedge clk);
    end
  endtask

  task automatic hold_watch(input int ch, input logic v, input string tag);
    logic [31:0] s;
    for (int j = 0; j <= DLY + 1; j++) begin
      rd(8'hEC, s);
      chk(tag, 32'(s[ch]), 32'(v));
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    for (int c = 0; c < NCH; c++) begin
      e0[c] = '0; e1[c] = '0; ea[c] = 32'h1B040010;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    cmp_outputs("R1");
    rd(8'hEC, r); chk("R1 status", r, 32'h0);
    rd(8'h1C, r); chk("R1 sel", r, 32'h0);

    // R2 staged only, R5 masking
    sel(0);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    cmp_outputs("R2 before commit");
    rd(8'h0C, r); chk("R2 readback w0", r, 32'h0);
    rd(8'h10, r); chk("R2 readback w1", r, 32'h0);
    wr(8'h1C, 32'h100);
    e0[0] = 32'hB00000FF; e1[0] = 32'h7F3FFFFF;
    // R8 lock rises exactly DLY edges after commit (en + lock enable set)
    lock_watch(0, "R8 first lock ch0");
    cmp_outputs("R3/R5 masked commit");
    rd(8'h0C, r); chk("R5 w0 readback", r, 32'hB00000FF);
    rd(8'h10, r); chk("R5 w1 readback", r, 32'h7F3FFFFF);
    rd(8'h1C, r); chk("R6 update bit reads zero", r, 32'h0);

    // sweep both channels with PLL disabled (R3, R6, R9)
    for (int k = 0; k < 16; k++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [31:0] w0, w1, an;
        w0 = 32'((k * 17 + c * 5) & 255) | (32'(k & 1) << 29) | 32'h0F00_0000;
        w1 = (32'((k * 9 + c) & 127) << 24) | 32'((k * 32'h3A5B1 + c) & 32'h3FFFFF) | 32'h0080_0000;
        an = 32'h1B040010 ^ (32'(k) << 12) ^ 32'(c);
        commit(c, w0, w1, an);
        cmp_outputs("R3 sweep");
        rd(8'h0C, r); chk("R6 sweep w0", r, e0[c]);
        rd(8'h10, r); chk("R6 sweep w1", r, e1[c]);
        rd(8'h18, r); chk("R6 sweep an", r, ea[c]);
        rd(8'h1C, r); chk("R6 sweep sel", r, 32'(c));
        rd(8'hEC, r); chk("R9 disabled not locked", r, 32'h0);
      end
    end

    // R4 restage on select: partial edit keeps other words
    sel(1);
    wr(8'h10, 32'h0500_1234);
    wr(8'h1C, 32'h100);
    e1[1] = 32'h0500_1234;
    cmp_outputs("R4 partial edit");
    sel(0);
    rd(8'h0C, r); chk("R4/R6 ch0 view", r, e0[0]);

    // R7 undefined addresses
    wr(8'h14, 32'hDEAD_BEEF);
    wr(8'hEC, 32'hFFFF_FFFF);
    wr(8'h00, 32'h1234_5678);
    rd(8'h14, r); chk("R7 read 0x14", r, 32'h0);
    rd(8'h00, r); chk("R7 read 0x00", r, 32'h0);
    rd(8'h20, r); chk("R7 read 0x20", r, 32'h0);
    rd(8'hEC, r); chk("R7 status untouched", r, 32'h0);
    wr(8'h1C, 32'h100);
    cmp_outputs("R7 staging untouched");

    // R8/R9/R10 lock sequencing on channel 1
    commit(1, 32'hB000_0005, 32'h0A00_0000, 32'h1B043010);
    lock_watch(1, "R8 lock ch1");
    rd(8'hEC, r); chk("R8 ch0 unaffected", r, 32'h2);
    commit(1, 32'hB000_0006, 32'h0A00_0000, 32'h1B043010);
    lock_watch(1, "R8 relock on divider change");
    commit(1, 32'hB000_0006, 32'h0A00_0001, 32'h1B043010);
    lock_watch(1, "R8 relock on fraction change");
    // R10 shutdown step one: clear output clock enable only
    commit(1, 32'h9000_0006, 32'h0A00_0001, 32'h1B040010);
    hold_watch(1, 1'b1, "R10 lock kept");
    cmp_outputs("R10 outputs");
    // R9 shutdown step two: PLL enable low
    wr(8'h0C, 32'h8000_0006);
    wr(8'h1C, 32'h100);
    e0[1] = 32'h8000_0006;
    hold_watch(1, 1'b0, "R9 enable off");
    // R9 lock-detect enable low
    commit(1, 32'hB000_0006, 32'h0A00_0001, 32'h0);
    lock_watch(1, "R8 lock again");
    commit(1, 32'h3000_0006, 32'h0A00_0001, 32'h0);
    hold_watch(1, 1'b0, "R9 lock enable off");
    cmp_outputs("final");

    finish_run();
  end
endmodule